// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page-table entries. It turns the page number of a virtual address into a physical frame number in a single parallel search. The offset bits pass through untouched and are joined below the frame number. Each entry carries the identifier of the address space that owns it, so translations for several processes can sit in the cache together. Each entry also carries a valid flag and a writable flag, and both are checked on every search.

A lookup presents an address-space identifier, a virtual address and a write flag. One cycle later the block returns three results: whether the translation succeeded, whether a write hit a read-only page, and the physical address. On a miss the requester fetches the entry from the page table elsewhere and writes it in through the refill port. A flush port invalidates either every entry or only the entries of one address space.

Top module: `tlb`

## Requirements
- R1: A successful lookup returns the physical address {frame, offset}, where the offset is the low OFF_W bits of the virtual address, passed through unchanged. With 2 offset bits, the mapping page 0 to frame 5 turns address 0 into 20, and the mapping page 3 to frame 2 turns address 13 into 9.
- R2: A lookup hits only when both the page number (virtual address bits above OFF_W) and the address-space identifier equal those stored in a valid entry.
- R3: An entry whose valid flag is clear never produces a hit. After reset every entry is invalid.
- R4: A write lookup that matches an entry whose writable flag is 0 gives rsp_fault=1, rsp_hit=0 and rsp_paddr=0. A read lookup of the same entry succeeds, and so does a write lookup of a writable entry.
- R5: A lookup with no matching entry gives rsp_hit=0, rsp_fault=0 and rsp_paddr=0.
- R6: rsp_valid is high in exactly the cycle after a cycle with lk_valid high. When rsp_valid is low, rsp_hit and rsp_fault are low.
- R7: A refill for a page not yet cached writes the lowest-numbered invalid entry.
- R8: When every entry is valid, a refill for a page not yet cached replaces the entry at a round-robin pointer. The pointer starts at 0 after reset, advances by one after each such replacement, and wraps from ENTRIES-1 back to 0.
- R9: A refill whose identifier and page number match a valid entry overwrites that entry in place, and no other entry is disturbed.
- R10: A flush with flush_all=1 invalidates every entry.
- R11: A flush with flush_all=0 invalidates only the entries whose identifier equals flush_asid.
- R12: A lookup in the same cycle as a refill of the same page reports a miss. The refilled entry hits from the next cycle on.
- R13: When a flush and a refill occur in the same cycle, the flush is applied first, so the refilled entry is valid afterwards. The refill slot is chosen from the state before the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | ASID_W | Address-space identifier of the lookup |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| lk_write | input | 1 | Lookup is a write access |
| rsp_valid | output | 1 | Result of last cycle's lookup is present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Write matched a read-only page |
| rsp_paddr | output | PFN_W+OFF_W | Physical address, 0 unless rsp_hit |
| fill_valid | input | 1 | Refill write |
| fill_asid | input | ASID_W | Identifier of the refilled entry |
| fill_vpn | input | VPN_W | Page number of the refilled entry |
| fill_pfn | input | PFN_W | Frame number of the refilled entry |
| fill_writable | input | 1 | Refilled page allows writes |
| flush_valid | input | 1 | Flush request |
| flush_all | input | 1 | Flush every entry instead of one identifier |
| flush_asid | input | ASID_W | Identifier to flush when flush_all is 0 |

## Verification
The bench builds the block with 4 entries, 2 offset bits, 4-bit page numbers, 3-bit frame numbers and 2-bit identifiers. With this configuration every combination of identifier, virtual address and access type (512 lookups) can be swept after each phase and compared against an arithmetic model. Four refills fill the array, so the round-robin pointer wraps within a few steps, and the worked example with 4-byte pages and 8 frames fits exactly.

// File: rtl/tlb.sv
module tlb #(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 8,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 20,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              lk_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr,
  input  logic              fill_valid,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_writable,
  input  logic              flush_valid,
  input  logic              flush_all,
  input  logic [ASID_W-1:0] flush_asid
);

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] wr_q;
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  wire [VPN_W-1:0] lk_vpn = lk_vaddr[VA_W-1:OFF_W];
  wire [OFF_W-1:0] lk_off = lk_vaddr[OFF_W-1:0];

  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] dup_vec;
  logic [ENTRIES-1:0] flush_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_q[g] && asid_q[g] == lk_asid && vpn_q[g] == lk_vpn;
    assign dup_vec[g]   = valid_q[g] && asid_q[g] == fill_asid && vpn_q[g] == fill_vpn;
    assign flush_vec[g] = flush_valid && (flush_all || asid_q[g] == flush_asid);
  end

  logic [PFN_W-1:0] pfn_sel;
  logic             wr_sel;
  always_comb begin
    pfn_sel = '0;
    wr_sel  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        pfn_sel = pfn_sel | pfn_q[i];
        wr_sel  = wr_sel | wr_q[i];
      end
    end
  end

  logic             has_free, has_dup;
  logic [IDX_W-1:0] free_idx, dup_idx, fill_idx;
  always_comb begin
    has_free = 1'b0;
    has_dup  = 1'b0;
    free_idx = '0;
    dup_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (dup_vec[i]) begin
        has_dup = 1'b1;
        dup_idx = IDX_W'(i);
      end
    end
    fill_idx = has_dup ? dup_idx : (has_free ? free_idx : rr_q);
  end

  wire evict = fill_valid && !has_dup && !has_free;

  logic [ENTRIES-1:0] valid_n;
  always_comb begin
    valid_n = valid_q & ~flush_vec;
    if (fill_valid) valid_n[fill_idx] = 1'b1;
  end

  wire any_hit   = |match_vec;
  wire fault_n   = lk_valid && any_hit && lk_write && !wr_sel;
  wire hit_n     = lk_valid && any_hit && !fault_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= '0;
      rr_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      valid_q   <= valid_n;
      if (evict) rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      rsp_valid <= lk_valid;
      rsp_hit   <= hit_n;
      rsp_fault <= fault_n;
      rsp_paddr <= hit_n ? {pfn_sel, lk_off} : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      asid_q[fill_idx] <= fill_asid;
      vpn_q[fill_idx]  <= fill_vpn;
      pfn_q[fill_idx]  <= fill_pfn;
      wr_q[fill_idx]   <= fill_writable;
    end
  end

endmodule

module tlb_chk #(
  parameter int ENTRIES = 16,
  parameter int PA_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               fill_valid,
  input logic               flush_valid,
  input logic               flush_all,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_fault,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic [ENTRIES-1:0] match_vec,
  input logic [ENTRIES-1:0] valid_q
);

  a_r6_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid && !rsp_hit && !rsp_fault);

  a_r4_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> !rsp_hit && rsp_paddr == '0);

  a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_paddr == '0);

  a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  a_r10_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid && flush_all && !fill_valid |=> valid_q == '0);

  a_r13_fill_survives: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid && flush_all && fill_valid |=> $countones(valid_q) == 1);

endmodule

bind tlb tlb_chk #(.ENTRIES(ENTRIES), .PA_W(PFN_W + OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .fill_valid(fill_valid),
  .flush_valid(flush_valid), .flush_all(flush_all), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
  .match_vec(match_vec), .valid_q(valid_q)
);

// File: tb/tb_tlb.sv
module tb_tlb;
  localparam int EN = 4, AW = 2, VW = 4, OW = 2, PW = 3;
  localparam int VAW = VW + OW, PAW = PW + OW;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, lk_write = 0;
  logic [AW-1:0] lk_asid = 0;
  logic [VAW-1:0] lk_vaddr = 0;
  logic rsp_valid, rsp_hit, rsp_fault;
  logic [PAW-1:0] rsp_paddr;
  logic fill_valid = 0, fill_writable = 0;
  logic [AW-1:0] fill_asid = 0;
  logic [VW-1:0] fill_vpn = 0;
  logic [PW-1:0] fill_pfn = 0;
  logic flush_valid = 0, flush_all = 0;
  logic [AW-1:0] flush_asid = 0;

  always #2 clk = ~clk;

  tlb #(.ENTRIES(EN), .ASID_W(AW), .VPN_W(VW), .OFF_W(OW), .PFN_W(PW)) dut (.*);

  int checks = 0, fails = 0;
  logic          m_v [EN];
  logic [AW-1:0] m_a [EN];
  logic [VW-1:0] m_p [EN];
  logic [PW-1:0] m_f [EN];
  logic          m_w [EN];
  int m_rr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pick(input logic [AW-1:0] a, input logic [VW-1:0] p);
    for (int i = 0; i < EN; i++) if (m_v[i] && m_a[i] == a && m_p[i] == p) return i;
    for (int i = 0; i < EN; i++) if (!m_v[i]) return i;
    return -1;
  endfunction

  task automatic model_fill(input logic [AW-1:0] a, input logic [VW-1:0] p,
                            input logic [PW-1:0] f, input logic w, input int idx);
    m_v[idx] = 1; m_a[idx] = a; m_p[idx] = p; m_f[idx] = f; m_w[idx] = w;
  endtask

  function automatic int slot_for(input logic [AW-1:0] a, input logic [VW-1:0] p);
    int s;
    s = pick(a, p);
    if (s < 0) begin
      s = m_rr;
      m_rr = (m_rr + 1) % EN;
    end
    return s;
  endfunction

  task automatic do_fill(input logic [AW-1:0] a, input logic [VW-1:0] p,
                         input logic [PW-1:0] f, input logic w);
    int s;
    @(negedge clk);
    fill_valid = 1; fill_asid = a; fill_vpn = p; fill_pfn = f; fill_writable = w;
    s = slot_for(a, p);
    @(negedge clk);
    fill_valid = 0;
    model_fill(a, p, f, w, s);
  endtask

  task automatic do_flush(input logic all, input logic [AW-1:0] a);
    @(negedge clk);
    flush_valid = 1; flush_all = all; flush_asid = a;
    @(negedge clk);
    flush_valid = 0;
    for (int i = 0; i < EN; i++) if (all || m_a[i] == a) m_v[i] = 0;
  endtask

  task automatic look(input logic [AW-1:0] a, input logic [VAW-1:0] va,
                      input logic w, input string tag);
    logic eh, ef;
    logic [PAW-1:0] ep;
    string req;
    eh = 0; ef = 0; ep = 0;
    for (int i = 0; i < EN; i++)
      if (m_v[i] && m_a[i] == a && m_p[i] == va[VAW-1:OW]) begin
        if (w && !m_w[i]) ef = 1;
        else begin eh = 1; ep = {m_f[i], va[OW-1:0]}; end
      end
    req = ef ? "R4" : (eh ? "R1/R2" : "R5/R3");
    @(negedge clk);
    lk_valid = 1; lk_asid = a; lk_vaddr = va; lk_write = w;
    @(negedge clk);
    lk_valid = 0;
    chk(rsp_valid == 1, {tag, " R6 rsp_valid"}, rsp_valid, 1);
    chk(rsp_hit == eh, {tag, " ", req, " hit"}, rsp_hit, eh);
    chk(rsp_fault == ef, {tag, " ", req, " fault"}, rsp_fault, ef);
    chk(rsp_paddr == ep, {tag, " ", req, " paddr"}, rsp_paddr, ep);
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < (1 << AW); a++)
      for (int v = 0; v < (1 << VAW); v++)
        for (int w = 0; w < 2; w++) look(AW'(a), VAW'(v), w[0], tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < EN; i++) begin
      m_v[i] = 0; m_a[i] = 0; m_p[i] = 0; m_f[i] = 0; m_w[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 0 && rsp_hit == 0 && rsp_fault == 0, "R6 reset outputs", rsp_valid, 0);
    sweep("R3 after reset");

    do_fill(2'd1, 4'd0, 3'd5, 1'b1);
    do_fill(2'd1, 4'd3, 3'd2, 1'b0);
    look(2'd1, 6'd0, 1'b0, "R1 worked");
    chk(rsp_paddr == 20, "R1 address 0 -> 20", rsp_paddr, 20);
    look(2'd1, 6'd13, 1'b0, "R1 worked");
    chk(rsp_paddr == 9, "R1 address 13 -> 9", rsp_paddr, 9);
    look(2'd1, 6'd13, 1'b1, "R4 write ro");
    chk(rsp_fault == 1 && rsp_hit == 0, "R4 write to read-only", rsp_fault, 1);
    look(2'd2, 6'd0, 1'b0, "R2 other asid");
    chk(rsp_hit == 0, "R2 asid mismatch misses", rsp_hit, 0);
    sweep("R2 two entries");

    do_fill(2'd2, 4'd0, 3'd7, 1'b1);
    do_flush(1'b0, 2'd1);
    sweep("R11 flush asid");
    do_fill(2'd3, 4'd9, 3'd1, 1'b1);
    look(2'd3, 6'h24, 1'b1, "R7 lowest free");
    chk(rsp_hit == 1, "R7 refill into freed slot", rsp_hit, 1);
    do_fill(2'd0, 4'd15, 3'd6, 1'b0);
    do_fill(2'd0, 4'd4, 3'd3, 1'b1);
    sweep("R8 full array");
    do_fill(2'd1, 4'd7, 3'd4, 1'b1);
    do_fill(2'd2, 4'd8, 3'd0, 1'b0);
    do_fill(2'd3, 4'd1, 3'd2, 1'b1);
    do_fill(2'd0, 4'd2, 3'd5, 1'b1);
    do_fill(2'd1, 4'd11, 3'd6, 1'b0);
    sweep("R8 round robin wrap");

    do_fill(2'd1, 4'd11, 3'd3, 1'b1);
    look(2'd1, 6'h2E, 1'b1, "R9 overwrite");
    chk(rsp_paddr == 5'h0E, "R9 in-place overwrite new frame", rsp_paddr, 5'h0E);
    sweep("R9 others intact");

    @(negedge clk);
    fill_valid = 1; fill_asid = 2'd2; fill_vpn = 4'd6; fill_pfn = 3'd7; fill_writable = 1;
    lk_valid = 1; lk_asid = 2'd2; lk_vaddr = 6'h1A; lk_write = 0;
    @(negedge clk);
    fill_valid = 0; lk_valid = 0;
    chk(rsp_hit == 0, "R12 same-cycle lookup misses", rsp_hit, 0);
    model_fill(2'd2, 4'd6, 3'd7, 1'b1, slot_for(2'd2, 4'd6));
    look(2'd2, 6'h1A, 1'b0, "R12 next cycle");
    chk(rsp_hit == 1 && rsp_paddr == 5'h1E, "R12 visible next cycle", rsp_paddr, 5'h1E);

    do_flush(1'b1, 2'd0);
    sweep("R10 flush all");

    do_fill(2'd0, 4'd1, 3'd1, 1'b1);
    do_fill(2'd0, 4'd2, 3'd2, 1'b1);
    begin
      int s;
      @(negedge clk);
      flush_valid = 1; flush_all = 1;
      fill_valid = 1; fill_asid = 2'd3; fill_vpn = 4'd12; fill_pfn = 3'd6; fill_writable = 0;
      s = slot_for(2'd3, 4'd12);
      @(negedge clk);
      flush_valid = 0; fill_valid = 0;
      for (int i = 0; i < EN; i++) m_v[i] = 0;
      model_fill(2'd3, 4'd12, 3'd6, 1'b0, s);
    end
    look(2'd3, 6'h31, 1'b0, "R13 flush+fill");
    chk(rsp_hit == 1 && rsp_paddr == 5'h19, "R13 fill survives flush", rsp_paddr, 5'h19);
    sweep("R13 after flush+fill");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule